// File: doc/BRIEF.md
# SDRAM Command Decoder and Mode Register Front End

This block is the device-side command front end of a synchronous DRAM model. On every rising clock edge it samples the clock enable, the four active-low command strobes, a 13-bit address and a 2-bit bank address. It turns them into one decoded command code together with that command's bank, address and precharge qualifiers. It also holds the two mode registers, so the rest of the model can read the programmed burst length, burst ordering, read latency, write-burst policy, refreshed-array size and output drive setting.

The block keeps its own open/closed record for each bank, built from activate and precharge commands. It uses that record and a short hold-off window after each mode register cycle to reject commands issued at an illegal time. A rejected command comes out as a no-operation with a one-cycle timing error pulse and changes no state. A mode register cycle that carries a reserved field value comes out as a mode command with a one-cycle mode error pulse and leaves both registers as they were. All outputs are registered and show the effect of the command sampled at the edge just before.

Top module: `sdram_cmd_front`

## Requirements
- R1: After synchronous reset: command output 0 (no-op), bank and address 0, both precharge flags and both error flags 0, burst length code 000, sequential ordering, read latency 3, write-single off, refreshed-array code 00 (full) and full drive.
- R2: With chip select (cs_n) low, the strobes {ras_n,cas_n,we_n} decode to these cmd_o codes: 011 activate=1, 101 read=2, 100 write=3, 110 burst stop=4, 010 precharge=5, 001 refresh=6 or self-refresh=7 (see R3), 000 mode set=8, 111 no-op=0. With cs_n high, cmd_o is 0. cmd_o shows the command sampled at the previous rising edge.
- R3: Strobes 001 decode as refresh (6) when clock enable was high at the previous edge and is high now, and as self-refresh entry (7) when it was high and is now low. Whenever clock enable was low at the previous edge, every input decodes as no-op.
- R4: bank_o equals the bank input for activate, read, write, precharge and mode set, and is 0 otherwise. addr_o is the full address for activate and mode set, address bits 8..0 zero-extended for read and write, and 0 otherwise. auto_pre_o equals address bit 10 on read and write and is 0 otherwise.
- R5: pre_all_o equals address bit 10 on precharge. A precharge closes every bank when that bit is high, and only the addressed bank when it is low.
- R6: A mode set with bank 00 loads the normal register: bits 2..0 give the burst length code (000, 001, 010, 011, or 111 for full page), bit 3 the ordering (1 = interleaved), bits 6..4 the read latency (1 to 3, shown on cas_lat_o), and bit 9 the single-beat write policy.
- R7: A mode set with bank 10 loads the extended register: bits 2..0 give the refreshed-array code (000 full, 001 half, 010 quarter, shown on pasr_o as 0, 1, 2), and bit 5 selects half drive.
- R8: A mode set is reserved, so both registers stay unchanged and mode_err_o pulses for one cycle, when any of these holds: burst code 100 to 110, full page with interleaved ordering, latency 000 or 1xx, bits 8..7 non-zero, bank 01 or 11, or an extended array code above 010.
- R9: A mode set, refresh or self-refresh entry while any bank is open is rejected: cmd_o shows 0, timing_err_o pulses, and no bank, register or hold-off state changes.
- R10: After an accepted mode set, any command other than no-op on the next MRD_GAP-1 edges (one edge by default) is rejected in the same way as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 13 | Address / mode operand |
| ba | input | 2 | Bank address / mode register select |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Bank of the decoded command |
| addr_o | output | 13 | Row, column or operand of the decoded command |
| auto_pre_o | output | 1 | Auto-precharge on read/write |
| pre_all_o | output | 1 | Precharge applies to all banks |
| burst_len_o | output | 3 | Burst length code |
| burst_ilv_o | output | 1 | Interleaved burst ordering |
| cas_lat_o | output | 2 | Read latency in clocks |
| write_single_o | output | 1 | Writes are single-beat |
| pasr_o | output | 2 | Refreshed-array size code |
| drive_half_o | output | 1 | Half output drive |
| mode_err_o | output | 1 | Reserved mode operand pulse |
| timing_err_o | output | 1 | Illegal command timing pulse |

## Verification
Two functions can act on the same edge. The hold-off after a mode set and the all-banks-idle rule both apply to a second mode set or refresh that comes straight after a mode set, and a mode set can also be timing-legal but carry a reserved operand. The bench provokes these cases directly, with an activate right after a mode set, mode sets and refreshes while banks are open, and reserved operands on legal cycles. It also drives long stretches of random strobes, clock enable and addresses. A behavioural reference model that keeps its own bank flags and hold-off counter is compared against every output on every cycle, so the bench confirms that the rejection always takes precedence and that a rejected command leaves no trace in the registers.

// File: rtl/sdram_fe_pkg.sv
package sdram_fe_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_BST  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_REF  = 4'd6,
    CMD_SREF = 4'd7,
    CMD_MODE = 4'd8
  } cmd_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_fe_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e raw_cmd
);

  always_comb begin
    raw_cmd = CMD_NOP;
    if (cke_prev && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  raw_cmd = CMD_MODE;
        3'b001:  raw_cmd = cke ? CMD_REF : CMD_SREF;
        3'b011:  raw_cmd = CMD_ACT;
        3'b101:  raw_cmd = CMD_RD;
        3'b100:  raw_cmd = CMD_WR;
        3'b110:  raw_cmd = CMD_BST;
        3'b010:  raw_cmd = CMD_PRE;
        default: raw_cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            act_en,
  input  logic            pre_en,
  input  logic            pre_all,
  input  logic [BA_W-1:0] bank,
  output logic            all_idle
);

  localparam int NBANK = 1 << BA_W;

  logic [NBANK-1:0] open_vec;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic open_q;
    always_ff @(posedge clk) begin
      if (rst)
        open_q <= 1'b0;
      else if (pre_en && (pre_all || bank == BA_W'(b)))
        open_q <= 1'b0;
      else if (act_en && bank == BA_W'(b))
        open_q <= 1'b1;
    end
    assign open_vec[b] = open_q;
  end

  assign all_idle = ~|open_vec;

  p_act_opens_r9: assert property (@(posedge clk) disable iff (rst)
    act_en |=> !all_idle);

  p_pre_all_closes_r5: assert property (@(posedge clk) disable iff (rst)
    (pre_en && pre_all) |=> all_idle);

endmodule

// File: rtl/sdram_mode_regs.sv
module sdram_mode_regs #(
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [BA_W-1:0] sel,
  input  logic [9:0]      op,
  output logic [2:0]      burst_len_o,
  output logic            burst_ilv_o,
  output logic [1:0]      cas_lat_o,
  output logic            write_single_o,
  output logic [1:0]      pasr_o,
  output logic            drive_half_o,
  output logic            mode_err_o
);

  localparam logic [BA_W-1:0] SEL_STD = '0;
  localparam logic [BA_W-1:0] SEL_EXT = BA_W'(2);

  logic [2:0] bl_f;
  logic [2:0] cl_f;
  logic       ilv_f;
  logic       std_ok;
  logic       ext_ok;

  always_comb begin
    bl_f   = op[2:0];
    ilv_f  = op[3];
    cl_f   = op[6:4];
    std_ok = (!bl_f[2] || (bl_f == 3'b111 && !ilv_f)) &&
             (cl_f != 3'd0 && !cl_f[2]) &&
             (op[8:7] == 2'b00);
    ext_ok = (op[2:0] <= 3'd2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_len_o    <= 3'b000;
      burst_ilv_o    <= 1'b0;
      cas_lat_o      <= 2'd3;
      write_single_o <= 1'b0;
      pasr_o         <= 2'd0;
      drive_half_o   <= 1'b0;
      mode_err_o     <= 1'b0;
    end else begin
      mode_err_o <= 1'b0;
      if (wr_en) begin
        if (sel == SEL_STD && std_ok) begin
          burst_len_o    <= bl_f;
          burst_ilv_o    <= ilv_f;
          cas_lat_o      <= cl_f[1:0];
          write_single_o <= op[9];
        end else if (sel == SEL_EXT && ext_ok) begin
          pasr_o       <= op[1:0];
          drive_half_o <= op[5];
        end else begin
          mode_err_o <= 1'b1;
        end
      end
    end
  end

  p_hold_on_reserved_r8: assert property (@(posedge clk) disable iff (rst)
    mode_err_o |-> $stable({burst_len_o, burst_ilv_o, cas_lat_o,
                            write_single_o, pasr_o, drive_half_o}));

  p_latency_legal_r6: assert property (@(posedge clk) disable iff (rst)
    cas_lat_o != 2'd0);

  p_array_legal_r7: assert property (@(posedge clk) disable iff (rst)
    pasr_o != 2'd3);

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_fe_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int COL_W   = 9,
  parameter int AP_BIT  = 10,
  parameter int MRD_GAP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BA_W-1:0]   ba,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              auto_pre_o,
  output logic              pre_all_o,
  output logic [2:0]        burst_len_o,
  output logic              burst_ilv_o,
  output logic [1:0]        cas_lat_o,
  output logic              write_single_o,
  output logic [1:0]        pasr_o,
  output logic              drive_half_o,
  output logic              mode_err_o,
  output logic              timing_err_o
);

  localparam int GAP_W = $clog2(MRD_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MRD_GAP - 1);

  logic             cke_q;
  logic [GAP_W-1:0] gap_q;
  logic             all_idle;
  logic             needs_idle;
  logic             illegal;
  cmd_e             raw_cmd;
  cmd_e             acc_cmd;

  sdram_cmd_decode u_dec (
    .cke_prev (cke_q),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .raw_cmd  (raw_cmd)
  );

  always_comb begin
    needs_idle = (raw_cmd == CMD_MODE) || (raw_cmd == CMD_REF) ||
                 (raw_cmd == CMD_SREF);
    illegal    = (needs_idle && !all_idle) ||
                 (raw_cmd != CMD_NOP && gap_q != '0);
    acc_cmd    = illegal ? CMD_NOP : raw_cmd;
  end

  sdram_bank_track #(.BA_W(BA_W)) u_banks (
    .clk      (clk),
    .rst      (rst),
    .act_en   (acc_cmd == CMD_ACT),
    .pre_en   (acc_cmd == CMD_PRE),
    .pre_all  (addr[AP_BIT]),
    .bank     (ba),
    .all_idle (all_idle)
  );

  sdram_mode_regs #(.BA_W(BA_W)) u_mode (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (acc_cmd == CMD_MODE),
    .sel            (ba),
    .op             (addr[9:0]),
    .burst_len_o    (burst_len_o),
    .burst_ilv_o    (burst_ilv_o),
    .cas_lat_o      (cas_lat_o),
    .write_single_o (write_single_o),
    .pasr_o         (pasr_o),
    .drive_half_o   (drive_half_o),
    .mode_err_o     (mode_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q        <= 1'b1;
      gap_q        <= '0;
      cmd_o        <= 4'(CMD_NOP);
      bank_o       <= '0;
      addr_o       <= '0;
      auto_pre_o   <= 1'b0;
      pre_all_o    <= 1'b0;
      timing_err_o <= 1'b0;
    end else begin
      cke_q        <= cke;
      cmd_o        <= 4'(acc_cmd);
      timing_err_o <= illegal;
      if (acc_cmd == CMD_MODE)
        gap_q <= GAP_LOAD;
      else if (gap_q != '0)
        gap_q <= gap_q - 1'b1;
      unique case (acc_cmd)
        CMD_ACT, CMD_MODE: begin
          bank_o <= ba;
          addr_o <= addr;
        end
        CMD_RD, CMD_WR: begin
          bank_o <= ba;
          addr_o <= {{(ADDR_W-COL_W){1'b0}}, addr[COL_W-1:0]};
        end
        CMD_PRE: begin
          bank_o <= ba;
          addr_o <= '0;
        end
        default: begin
          bank_o <= '0;
          addr_o <= '0;
        end
      endcase
      auto_pre_o <= (acc_cmd == CMD_RD || acc_cmd == CMD_WR) && addr[AP_BIT];
      pre_all_o  <= (acc_cmd == CMD_PRE) && addr[AP_BIT];
    end
  end

  p_reject_is_nop_r9: assert property (@(posedge clk) disable iff (rst)
    timing_err_o |-> cmd_o == 4'(CMD_NOP));

  p_idle_for_mode_refresh_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 4'(CMD_MODE) || cmd_o == 4'(CMD_REF) || cmd_o == 4'(CMD_SREF))
      |-> all_idle);

  p_mode_err_on_mode_r8: assert property (@(posedge clk) disable iff (rst)
    mode_err_o |-> cmd_o == 4'(CMD_MODE));

  if (MRD_GAP >= 2) begin : g_gap_chk
    p_gap_after_mode_r10: assert property (@(posedge clk) disable iff (rst)
      cmd_o == 4'(CMD_MODE) |=> cmd_o == 4'(CMD_NOP));
  end

endmodule

// File: tb/sdram_cmd_front_test.sv
module sdram_cmd_front_test;

  localparam int MRD_GAP = 2;
  localparam logic [3:0] C_MODE = 4'b0000, C_REF = 4'b0001, C_ACT = 4'b0011,
                         C_RD = 4'b0101, C_WR = 4'b0100, C_BST = 4'b0110,
                         C_PRE = 4'b0010, C_NOP = 4'b0111;
  localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_BST = 4,
                 K_PRE = 5, K_REF = 6, K_SREF = 7, K_MODE = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [1:0]  ba = '0;
  logic [3:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] addr_o;
  logic auto_pre_o, pre_all_o, burst_ilv_o, write_single_o, drive_half_o;
  logic mode_err_o, timing_err_o;
  logic [2:0] burst_len_o;
  logic [1:0] cas_lat_o, pasr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  bit live = 0;

  // reference model state
  int m_ckep, m_gap, raw, acc;
  bit m_open [4];
  bit any_open, illegal, ok;
  int e_cmd, e_bank, e_addr, e_ap, e_pall, e_bl, e_ilv, e_cl, e_ws;
  int e_pasr, e_dh, e_merr, e_terr;

  always #5 clk = ~clk;

  sdram_cmd_front uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .cmd_o(cmd_o),
    .bank_o(bank_o), .addr_o(addr_o), .auto_pre_o(auto_pre_o),
    .pre_all_o(pre_all_o), .burst_len_o(burst_len_o),
    .burst_ilv_o(burst_ilv_o), .cas_lat_o(cas_lat_o),
    .write_single_o(write_single_o), .pasr_o(pasr_o),
    .drive_half_o(drive_half_o), .mode_err_o(mode_err_o),
    .timing_err_o(timing_err_o)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // behavioural reference model, evaluated at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      live = 0; m_ckep = 1; m_gap = 0;
      for (int i = 0; i < 4; i++) m_open[i] = 0;
      e_cmd = K_NOP; e_bank = 0; e_addr = 0; e_ap = 0; e_pall = 0;
      e_bl = 0; e_ilv = 0; e_cl = 3; e_ws = 0; e_pasr = 0; e_dh = 0;
      e_merr = 0; e_terr = 0;
    end else begin
      live = 1;
      raw = K_NOP;
      if (m_ckep == 1 && !cs_n) begin
        case ({ras_n, cas_n, we_n})
          3'b000: raw = K_MODE;
          3'b001: raw = cke ? K_REF : K_SREF;
          3'b011: raw = K_ACT;
          3'b101: raw = K_RD;
          3'b100: raw = K_WR;
          3'b110: raw = K_BST;
          3'b010: raw = K_PRE;
          default: raw = K_NOP;
        endcase
      end
      any_open = m_open[0] | m_open[1] | m_open[2] | m_open[3];
      illegal = ((raw == K_MODE || raw == K_REF || raw == K_SREF) && any_open) ||
                (raw != K_NOP && m_gap > 0);
      acc = illegal ? K_NOP : raw;
      e_cmd = acc; e_terr = illegal; e_merr = 0;
      e_bank = 0; e_addr = 0;
      if (acc == K_ACT || acc == K_MODE) begin e_bank = ba; e_addr = addr; end
      if (acc == K_RD || acc == K_WR) begin e_bank = ba; e_addr = addr & 13'h1FF; end
      if (acc == K_PRE) e_bank = ba;
      e_ap = (acc == K_RD || acc == K_WR) ? addr[10] : 0;
      e_pall = (acc == K_PRE) ? addr[10] : 0;
      if (acc == K_MODE) begin
        ok = 0;
        if (ba == 2'b00) begin
          ok = (addr[2:0] <= 3 || (addr[2:0] == 7 && !addr[3])) &&
               (addr[6:4] >= 1 && addr[6:4] <= 3) && addr[8:7] == 0;
          if (ok) begin
            e_bl = addr[2:0]; e_ilv = addr[3]; e_cl = addr[6:4]; e_ws = addr[9];
          end
        end else if (ba == 2'b10) begin
          ok = addr[2:0] <= 2;
          if (ok) begin e_pasr = addr[2:0]; e_dh = addr[5]; end
        end
        e_merr = !ok;
      end
      if (acc == K_ACT) m_open[ba] = 1;
      if (acc == K_PRE) begin
        if (addr[10]) for (int i = 0; i < 4; i++) m_open[i] = 0;
        else m_open[ba] = 0;
      end
      if (acc == K_MODE) m_gap = MRD_GAP - 1;
      else if (m_gap > 0) m_gap--;
      m_ckep = cke;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk("R2", "cmd", cmd_o, e_cmd);
      chk("R4", "bank/addr/ap", {bank_o, addr_o, auto_pre_o}, {e_bank[1:0], e_addr[12:0], e_ap[0]});
      chk("R5", "pre_all", pre_all_o, e_pall);
      chk("R6", "std regs", {burst_len_o, burst_ilv_o, cas_lat_o, write_single_o},
          {e_bl[2:0], e_ilv[0], e_cl[1:0], e_ws[0]});
      chk("R7", "ext regs", {pasr_o, drive_half_o}, {e_pasr[1:0], e_dh[0]});
      chk("R8", "mode_err", mode_err_o, e_merr);
      chk("R9", "timing_err", timing_err_o, e_terr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    addr = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "cmd", cmd_o, 0);
    chk("R1", "regs", {burst_len_o, burst_ilv_o, cas_lat_o, write_single_o, pasr_o, drive_half_o},
        {3'b000, 1'b0, 2'd3, 1'b0, 2'd0, 1'b0});
    chk("R1", "flags", {mode_err_o, timing_err_o, auto_pre_o, pre_all_o}, 0);
    rst = 1'b0;
    issue(C_NOP, 0, 0);
    issue(4'b1000, 0, 0);
    chk("R2", "deselect", cmd_o, K_NOP);
    issue(C_MODE, 2'b00, 13'h022);
    chk("R6", "burst len", burst_len_o, 2);
    chk("R6", "latency", cas_lat_o, 2);
    issue(C_ACT, 0, 13'd5);
    chk("R10", "gap reject", {timing_err_o, cmd_o}, {1'b1, 4'd0});
    issue(C_NOP, 0, 0);
    issue(C_MODE, 2'b10, 13'h021);
    chk("R7", "pasr/drive", {pasr_o, drive_half_o}, {2'd1, 1'b1});
    issue(C_NOP, 0, 0);
    issue(C_ACT, 2'd1, 13'h1ABC);
    chk("R4", "row", addr_o, 13'h1ABC);
    issue(C_ACT, 2'd2, 13'd5);
    issue(C_RD, 2'd1, 13'h1DFF);
    chk("R4", "column+ap", {addr_o, auto_pre_o}, {13'h1FF, 1'b1});
    issue(C_WR, 2'd2, 13'd3);
    chk("R4", "write", {cmd_o, auto_pre_o}, {4'd3, 1'b0});
    issue(C_BST, 0, 0);
    issue(C_MODE, 2'b00, 13'h033);
    chk("R9", "mode while open", {timing_err_o, cas_lat_o}, {1'b1, 2'd2});
    issue(C_REF, 0, 0);
    chk("R9", "refresh while open", timing_err_o, 1);
    issue(C_PRE, 2'd1, 13'h000);
    chk("R5", "single pre", {cmd_o, pre_all_o}, {4'd5, 1'b0});
    issue(C_REF, 0, 0);
    chk("R5", "bank2 still open", timing_err_o, 1);
    issue(C_PRE, 2'd0, 13'h400);
    chk("R5", "pre all", pre_all_o, 1);
    issue(C_REF, 0, 0);
    chk("R5", "refresh after pre all", cmd_o, K_REF);
    issue(C_MODE, 2'b00, 13'h024); chk("R8", "bl 100", {mode_err_o, burst_len_o}, {1'b1, 3'd2});
    issue(C_NOP, 0, 0);
    issue(C_MODE, 2'b00, 13'h002); chk("R8", "cl 000", mode_err_o, 1);
    issue(C_NOP, 0, 0);
    issue(C_MODE, 2'b00, 13'h02F); chk("R8", "full page ilv", {mode_err_o, burst_ilv_o}, {1'b1, 1'b0});
    issue(C_NOP, 0, 0);
    issue(C_MODE, 2'b00, 13'h122); chk("R8", "bit8 set", mode_err_o, 1);
    issue(C_NOP, 0, 0);
    issue(C_MODE, 2'b01, 13'h022); chk("R8", "bank 01", mode_err_o, 1);
    issue(C_NOP, 0, 0);
    issue(C_MODE, 2'b10, 13'h003); chk("R8", "pasr 011", {mode_err_o, pasr_o}, {1'b1, 2'd1});
    issue(C_NOP, 0, 0);
    issue(C_MODE, 2'b00, 13'h237);
    chk("R6", "full page single write", {burst_len_o, cas_lat_o, write_single_o}, {3'd7, 2'd3, 1'b1});
    issue(C_NOP, 0, 0);
    cke = 1'b0;
    issue(C_REF, 0, 0);
    chk("R3", "self refresh entry", cmd_o, K_SREF);
    issue(C_ACT, 0, 0);
    chk("R3", "ignored while cke low", cmd_o, K_NOP);
    cke = 1'b1;
    issue(C_NOP, 0, 0);
    issue(C_REF, 0, 0);
    chk("R3", "auto refresh", cmd_o, K_REF);
    for (int n = 0; n < 3000; n++) begin
      {cs_n, ras_n, cas_n, we_n} = 4'($urandom);
      cs_n = ($urandom % 4 == 0);
      cke = ($urandom % 10 != 0);
      addr = 13'($urandom);
      ba = 2'($urandom);
      @(negedge clk);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule